// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous request port and an external asynchronous static RAM that is 16 bits wide with two byte lanes. Each accepted request is a single word access, either a read or a write. The block turns it into a timed sequence on the memory pins: a pair of chip enables (one active low, one active high), an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The data bus is split into an output word, an input word and a drive-enable, so the pad ring can build the tristate.

Every timing rule of the memory is a parameter counted in clock cycles, and each phase of a sequence has its own count. A write has an address setup phase, a strobe pulse and a hold phase. A read has an access phase and, when the minimum read cycle needs it, a recovery phase. A write that follows a read first waits out a bus turnaround phase. The controller accepts one request at a time. `req_ready_o` is high only while it is idle. Read data comes back with a one-cycle `rsp_valid_o` pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it: `sram_ce1_no`=1, `sram_ce2_o`=0, `sram_we_no`=1, `sram_oe_no`=1, `sram_ben_no`=2'b11, `sram_dq_oe_o`=0, `req_ready_o`=1, `rsp_valid_o`=0.
- R2: During a write sequence the chip is enabled (`sram_ce1_no`=0, `sram_ce2_o`=1) and `sram_oe_no` stays high. `sram_dq_oe_o` is high only while a write sequence is running. When the strobe falls, `sram_ben_no[i]` is the inverse of request mask bit `req_ben_i[i]`, where bit 0 is data bits 7:0 and bit 1 is bits 15:8.
- R3: Address and chip enable are stable for at least T_ASU cycles before `sram_we_no` falls.
- R4: `sram_we_no` stays low for at least max(T_WP, T_DS, T_AW−T_ASU) cycles. When it rises, the address has been stable for at least T_AW cycles and the driven data for at least T_DS cycles.
- R5: After `sram_we_no` rises, the address, the driven data and the chip enable stay unchanged for at least T_HOLD cycles.
- R6: A read enables the chip, keeps `sram_we_no` high and holds `sram_oe_no` low for exactly T_ACC cycles. The bus is sampled on the last of those cycles, and the returned lanes equal the memory contents.
- R7: `rsp_valid_o` is a single-cycle pulse in the cycle after the last access cycle. Lanes whose mask bit is 0 read as zero in `rsp_rdata_o`.
- R8: Two successive falls of `sram_oe_no` are at least T_RC cycles apart.
- R9: After a read, `sram_dq_oe_o` does not rise until at least T_TURN cycles after `sram_oe_no` went high.
- R10: `req_ready_o` is low from the cycle after a request is accepted until its sequence has completed.
- R11: A write with mask 2'b00 runs its sequence but no byte enable falls, so the memory keeps its contents.
- R12: A write changes only the lanes whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken on valid and ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ben_i | input | DATA_W/8 | Lane mask, bit 0 = bits 7:0 |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data, unselected lanes zero |
| sram_addr_o | output | ADDR_W | Memory address |
| sram_ce1_no | output | 1 | Chip enable, active low |
| sram_ce2_o | output | 1 | Chip enable, active high |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_ben_no | output | DATA_W/8 | Lane enables, active low |
| sram_dq_o | output | DATA_W | Data to memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DATA_W | Data from memory |

## Verification
The bench builds the block with an 8-bit address and setup 2, write pulse 3, data setup 4, address-to-end 7, hold 2, access 3, read cycle 7 and turnaround 2. With these values the address-to-end term (7−2=5) sets the strobe length instead of the raw pulse width. The read cycle forces a recovery phase of three cycles, so back-to-back reads land exactly on the minimum spacing. A memory model that returns corrupted data until the access count is met exposes any early sample. Directed partial-mask, zero-mask and top-address accesses plus read-then-write pairs reach the lane and turnaround corners.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RREC
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // phase length is counted down one per cycle, never wraps
  a_r4_timer_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_timer_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_ASU  = 1,
  parameter int T_WP   = 2,
  parameter int T_DS   = 2,
  parameter int T_AW   = 3,
  parameter int T_HOLD = 1,
  parameter int T_ACC  = 2,
  parameter int T_RC   = 3,
  parameter int T_TURN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic we_i,
  output logic idle_o,
  output logic cap_o,
  output logic ce_act_o,
  output logic we_act_o,
  output logic oe_act_o,
  output logic lane_act_o,
  output logic drive_o
);

  localparam int AW_REM = (T_AW > T_ASU) ? (T_AW - T_ASU) : 1;
  localparam int PULSE  = int'(max2(max2(T_WP, T_DS), AW_REM));
  localparam int REC    = (T_RC > T_ACC + 1) ? (T_RC - T_ACC - 1) : 0;
  localparam bit HAS_REC = (REC > 0);
  localparam int MAXLEN = int'(max2(max2(max2(T_ASU, PULSE), max2(T_HOLD, T_ACC)),
                                    max2(REC, T_TURN)));
  localparam int CNT_W  = (MAXLEN < 2) ? 1 : $clog2(MAXLEN);

  seq_state_e state_q, state_d;
  logic tmr_done, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic turn_pend_q;
  logic ce_q, we_q, oe_q, lane_q, drv_q;
  logic after_rd;

  function automatic logic [CNT_W-1:0] len_m1(input seq_state_e s);
    case (s)
      ST_TURN:   return CNT_W'(T_TURN - 1);
      ST_WSETUP: return CNT_W'(T_ASU - 1);
      ST_WPULSE: return CNT_W'(PULSE - 1);
      ST_WHOLD:  return CNT_W'(T_HOLD - 1);
      ST_RACC:   return CNT_W'(T_ACC - 1);
      ST_RREC:   return CNT_W'(HAS_REC ? REC - 1 : 0);
      default:   return '0;
    endcase
  endfunction

  generate
    if (HAS_REC) begin : g_rec
      assign after_rd = 1'b1;
    end else begin : g_norec
      assign after_rd = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = we_i ? (turn_pend_q ? ST_TURN : ST_WSETUP) : ST_RACC;
      ST_TURN:   if (tmr_done) state_d = ST_WSETUP;
      ST_WSETUP: if (tmr_done) state_d = ST_WPULSE;
      ST_WPULSE: if (tmr_done) state_d = ST_WHOLD;
      ST_WHOLD:  if (tmr_done) state_d = ST_IDLE;
      ST_RACC:   if (tmr_done) state_d = after_rd ? ST_RREC : ST_IDLE;
      ST_RREC:   if (tmr_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = len_m1(state_d);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      turn_pend_q <= 1'b0;
      ce_q        <= 1'b0;
      we_q        <= 1'b0;
      oe_q        <= 1'b0;
      lane_q      <= 1'b0;
      drv_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RACC && tmr_done) turn_pend_q <= 1'b1;
      else if (state_q == ST_TURN)        turn_pend_q <= 1'b0;
      // strobes registered from next state: glitch-free pins
      ce_q   <= state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC};
      lane_q <= state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC};
      we_q   <= (state_d == ST_WPULSE);
      oe_q   <= (state_d == ST_RACC);
      drv_q  <= state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD};
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign cap_o      = (state_q == ST_RACC) && tmr_done;
  assign ce_act_o   = ce_q;
  assign we_act_o   = we_q;
  assign oe_act_o   = oe_q;
  assign lane_act_o = lane_q;
  assign drive_o    = drv_q;

  a_r2_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && oe_q));
  a_r2_drive_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> (!oe_q && ce_q));
  a_r3_ce_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_q) |-> $past(ce_q));
  a_r5_ce_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_q) |-> ce_q);
  a_r9_no_drive_after_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> !$past(oe_q));
  a_r6_cap_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (oe_q && !we_q));

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lane_act_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [LANES-1:0]  ben_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ben_no[l] = ~(lane_act_i & mask_i[l]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rdata_q[l*8 +: 8] <= '0;
      else if (cap_i) rdata_q[l*8 +: 8] <= mask_i[l] ? dq_i[l*8 +: 8] : 8'h00;
    end

    a_r7_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rvalid_q && !mask_i[l]) |-> (rdata_q[l*8 +: 8] == 8'h00));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= cap_i;
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int T_ASU  = 1,
  parameter int T_WP   = 2,
  parameter int T_DS   = 2,
  parameter int T_AW   = 3,
  parameter int T_HOLD = 1,
  parameter int T_ACC  = 2,
  parameter int T_RC   = 3,
  parameter int T_TURN = 1,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_ben_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce1_no,
  output logic              sram_ce2_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [LANES-1:0]  sram_ben_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  logic              idle, start, cap;
  logic              ce_act, we_act, oe_act, lane_act, drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  assign start = req_valid_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      mask_q  <= req_ben_i;
    end
  end

  sram_seq_fsm #(
    .T_ASU (T_ASU), .T_WP (T_WP), .T_DS (T_DS), .T_AW (T_AW),
    .T_HOLD(T_HOLD), .T_ACC(T_ACC), .T_RC(T_RC), .T_TURN(T_TURN)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .we_i       (req_we_i),
    .idle_o     (idle),
    .cap_o      (cap),
    .ce_act_o   (ce_act),
    .we_act_o   (we_act),
    .oe_act_o   (oe_act),
    .lane_act_o (lane_act),
    .drive_o    (drive)
  );

  sram_lane_io #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_act_i (lane_act),
    .mask_i     (mask_q),
    .cap_i      (cap),
    .dq_i       (sram_dq_i),
    .ben_no     (sram_ben_no),
    .rdata_o    (rsp_rdata_o),
    .rvalid_o   (rsp_valid_o)
  );

  assign req_ready_o  = idle;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = drive;
  assign sram_ce1_no  = ~ce_act;
  assign sram_ce2_o   = ce_act;
  assign sram_we_no   = ~we_act;
  assign sram_oe_no   = ~oe_act;

  a_r5_addr_stable_while_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce1_no && $past(!sram_ce1_no)) |-> $stable(sram_addr_o));
  a_r5_data_stable_while_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));
  a_r10_ready_means_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce1_no && !sram_dq_oe_o));
  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;

  localparam int AW = 8, DW = 16, LN = 2;
  localparam int T_ASU = 2, T_WP = 3, T_DS = 4, T_AW = 7, T_HOLD = 2;
  localparam int T_ACC = 3, T_RC = 7, T_TURN = 2;
  localparam int PMIN = 5; // max(3, 4, 7-2)

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [LN-1:0] req_ben_i = '0;
  logic req_ready_o, rsp_valid_o, sram_ce1_no, sram_ce2_o, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [DW-1:0] rsp_rdata_o, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr_o;
  logic [LN-1:0] sram_ben_no;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_ASU(T_ASU), .T_WP(T_WP), .T_DS(T_DS), .T_AW(T_AW),
    .T_HOLD(T_HOLD), .T_ACC(T_ACC), .T_RC(T_RC), .T_TURN(T_TURN)
  ) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_checks = 0, n_err = 0;
  bit finished = 1'b0;
  logic [DW-1:0] sram_mem [256];
  logic [DW-1:0] ref_mem  [256];
  logic [LN-1:0] cur_ben = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory model
  int rd_age = 0;
  logic ce_act_c, rd_cond_c;
  assign ce_act_c  = !sram_ce1_no && sram_ce2_o;
  assign rd_cond_c = ce_act_c && sram_we_no && !sram_oe_no && (sram_ben_no != 2'b11);
  always_comb begin
    if (rd_cond_c && rd_age >= T_ACC - 1) sram_dq_i = sram_mem[sram_addr_o];
    else                                  sram_dq_i = ~sram_mem[sram_addr_o];
  end

  // monitor state
  logic p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b0, p_dqoe = 1'b0, p_wr = 1'b0, p_rd = 1'b0;
  logic [AW-1:0] p_addr = '0, h_addr = '0;
  logic [DW-1:0] p_dq = '0, h_dq = '0;
  logic [LN-1:0] p_ben = '1;
  int asu_cnt = 0, pw_cnt = 0, addr_age = 0, dq_age = 0, hold_cnt = 0;
  int oe_low = 0, rd_gap = 0, turn_cnt = 0;
  bit hold_act = 0, seen_rd = 0, rd_last = 0, pulse_oe_ok = 1;

  always @(negedge clk_i) begin
    logic wr_c;
    wr_c = ce_act_c && !sram_we_no && (sram_ben_no != 2'b11);
    if (!rst_ni) begin
      p_we = 1; p_oe = 1; p_ce = 0; p_dqoe = 0; p_wr = 0; p_rd = 0;
      hold_act = 0; seen_rd = 0; rd_last = 0; rd_age = 0;
      asu_cnt = 0; pw_cnt = 0; addr_age = 0; dq_age = 0; oe_low = 0;
    end else begin
      // model write at end of write condition
      if (p_wr && !wr_c)
        for (int l = 0; l < LN; l++)
          if (!p_ben[l]) sram_mem[p_addr][l*8 +: 8] = p_dq[l*8 +: 8];
      // write strobe falls
      if (!sram_we_no && p_we) begin
        chk(asu_cnt >= T_ASU, "R3 address setup", asu_cnt, T_ASU);
        chk(sram_ben_no == ~cur_ben, "R2 R11 lane enables", sram_ben_no, ~cur_ben);
        pulse_oe_ok = sram_oe_no;
      end else if (!sram_we_no && !sram_oe_no) pulse_oe_ok = 0;
      // write strobe rises
      if (sram_we_no && !p_we) begin
        chk(pw_cnt >= PMIN, "R4 pulse width", pw_cnt, PMIN);
        chk(addr_age >= T_AW, "R4 address to end", addr_age, T_AW);
        chk(dq_age >= T_DS, "R4 data setup", dq_age, T_DS);
        chk(pulse_oe_ok, "R2 oe high in write", pulse_oe_ok, 1);
        hold_act = 1; hold_cnt = 0; h_addr = p_addr; h_dq = p_dq;
      end
      if (hold_act) begin
        if (ce_act_c && sram_we_no && sram_dq_oe_o && sram_addr_o == h_addr && sram_dq_o == h_dq)
          hold_cnt++;
        else begin
          chk(hold_cnt >= T_HOLD, "R5 hold", hold_cnt, T_HOLD);
          hold_act = 0;
        end
      end
      // read strobes
      if (!sram_oe_no && p_oe) begin
        if (seen_rd) chk(rd_gap >= T_RC, "R8 read cycle", rd_gap, T_RC);
        seen_rd = 1; rd_gap = 0;
      end
      if (sram_oe_no && !p_oe) begin
        chk(oe_low == T_ACC, "R6 access length", oe_low, T_ACC);
        rd_last = 1; turn_cnt = 0;
      end
      if (sram_dq_oe_o && !p_dqoe) begin
        if (rd_last) chk(turn_cnt >= T_TURN, "R9 turnaround", turn_cnt, T_TURN);
        rd_last = 0;
      end
      if (sram_dq_oe_o) chk(sram_oe_no && ce_act_c, "R2 drive only in write", {sram_oe_no, ce_act_c}, 2'b11);
      // counter updates
      if (ce_act_c && sram_we_no) asu_cnt = (p_ce && sram_addr_o == p_addr) ? asu_cnt + 1 : 1;
      else asu_cnt = 0;
      pw_cnt   = !sram_we_no ? pw_cnt + 1 : 0;
      addr_age = ce_act_c ? ((p_ce && sram_addr_o == p_addr) ? addr_age + 1 : 1) : 0;
      dq_age   = sram_dq_oe_o ? ((p_dqoe && sram_dq_o == p_dq) ? dq_age + 1 : 1) : 0;
      oe_low   = !sram_oe_no ? oe_low + 1 : 0;
      rd_gap++;
      turn_cnt++;
      rd_age = rd_cond_c ? ((p_rd && sram_addr_o == p_addr) ? rd_age + 1 : 0) : 0;
      p_we = sram_we_no; p_oe = sram_oe_no; p_ce = ce_act_c; p_dqoe = sram_dq_oe_o;
      p_addr = sram_addr_o; p_dq = sram_dq_o; p_ben = sram_ben_no; p_wr = wr_c; p_rd = rd_cond_c;
    end
  end

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [LN-1:0] m);
    logic [DW-1:0] v = '0;
    for (int l = 0; l < LN; l++) if (m[l]) v[l*8 +: 8] = ref_mem[a][l*8 +: 8];
    return v;
  endfunction

  task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [LN-1:0] m);
    logic [DW-1:0] e;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_ben_i = m; cur_ben = m;
    @(negedge clk_i);
    req_valid_i = 0;
    chk(!req_ready_o, "R10 busy after accept", req_ready_o, 0);
    if (we) begin
      for (int l = 0; l < LN; l++) if (m[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
      while (!req_ready_o) @(negedge clk_i);
    end else begin
      e = exp_read(a, m);
      while (!rsp_valid_o) @(negedge clk_i);
      chk(rsp_rdata_o == e, "R6 R7 R11 R12 read data", rsp_rdata_o, e);
      @(negedge clk_i);
      chk(!rsp_valid_o, "R7 single pulse", rsp_valid_o, 0);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) begin
      sram_mem[i] = 16'(i * 16'h0101) ^ 16'h3c5a;
      ref_mem[i]  = sram_mem[i];
    end
    repeat (3) @(negedge clk_i);
    chk({sram_ce1_no, sram_ce2_o, sram_we_no, sram_oe_no, sram_ben_no, sram_dq_oe_o} == 7'b1011110,
        "R1 reset strobes", {sram_ce1_no, sram_ce2_o, sram_we_no, sram_oe_no, sram_ben_no, sram_dq_oe_o}, 7'b1011110);
    chk(req_ready_o && !rsp_valid_o, "R1 reset handshake", {req_ready_o, rsp_valid_o}, 2'b10);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o && sram_ce1_no && !sram_dq_oe_o, "R1 idle after reset",
        {req_ready_o, sram_ce1_no, sram_dq_oe_o}, 3'b110);
    // directed corners
    do_req(1, 8'h10, 16'h1234, 2'b11);
    do_req(0, 8'h10, 16'h0, 2'b11);
    do_req(1, 8'h10, 16'hABCD, 2'b01);   // R12 low lane only
    do_req(0, 8'h10, 16'h0, 2'b11);
    do_req(1, 8'h10, 16'h5678, 2'b10);   // R12 high lane only
    do_req(0, 8'h10, 16'h0, 2'b10);      // R7 low lane zero
    do_req(1, 8'h10, 16'hFFFF, 2'b00);   // R11 zero mask
    do_req(0, 8'h10, 16'h0, 2'b11);
    do_req(1, 8'hFF, 16'hBEEF, 2'b11);
    do_req(0, 8'hFF, 16'h0, 2'b11);      // R8 back-to-back reads
    do_req(0, 8'h10, 16'h0, 2'b01);
    do_req(0, 8'h00, 16'h0, 2'b00);
    // constrained random
    for (int n = 0; n < 150; n++) begin
      bit we = $urandom_range(1, 0) == 1;
      logic [AW-1:0] a = ($urandom_range(9, 0) == 0) ? AW'($urandom) : AW'($urandom_range(15, 0));
      do_req(we, a, DW'($urandom), LN'($urandom_range(3, 0)));
    end
    repeat (10) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

endmodule